// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel attached to a free-running counter that lives elsewhere. The channel sees the current counter value and a one-cycle strobe that marks the counter wrapping. The wrap is also where each PWM period begins. A two-bit mode field picks one of three jobs. The channel can snapshot the counter when its input pin rises. It can toggle its output pin when the counter reaches a programmed value. It can produce a single-edge PWM waveform.

Software reaches the channel through a byte-wide register port. Two locations hold the 16-bit channel value, most significant byte first. A third location holds the mode and two control bits. The first control bit toggles the pin on every counter wrap in compare mode. The second forces the PWM output to full duty, but only from the period after the bit changes. Two hold mechanisms keep multi-byte accesses coherent. Reading the upper byte of a captured value freezes capture until the lower byte is read. Writing the upper byte of a compare value suspends matching until the lower byte arrives.

The outputs are the channel pin level and a one-cycle event pulse. The pulse marks either a capture or a compare match.

Top module: `tim_channel`

## Requirements
- R1: After reset the pin output is low, the event pulse is low, the channel value is zero and the control byte is zero, which selects capture mode.
- R2: Register address 0 holds value bits 15:8 and address 1 holds bits 7:0. Address 2 is the control byte: bit 0 is toggle-on-wrap, bit 1 is full-duty, and bits 3:2 are the mode (00 capture, 01 compare, 10 or 11 PWM). Reads return the stored contents, with upper control bits and address 3 reading as zero.
- R3: In capture mode a rising edge on the capture pin passes through a SYNC_STAGES-flop synchronizer. On the following clock the counter value is loaded into the channel value, and the event output pulses for exactly one cycle.
- R4: In capture mode a read of address 0 blocks all further captures. A later read of address 1 lifts the block, and captures resume after it.
- R5: In compare mode, each cycle where the counter equals the channel value toggles the pin on the next clock and pulses the event output.
- R6: In compare mode with toggle-on-wrap set, the pin also toggles on every counter wrap.
- R7: When a wrap and a match fall in the same cycle with toggle-on-wrap set, the pin toggles exactly once, not twice.
- R8: In capture mode the pin never changes, whatever the toggle-on-wrap bit holds.
- R9: In PWM mode the pin goes high on the clock after a wrap and low on the clock after a match. The wrap wins when both fall in the same cycle.
- R10: The full-duty bit is sampled only at counter wraps. While the sampled copy is set and toggle-on-wrap is clear, a PWM match does not pull the pin low. A write to the bit therefore first shows in the period after the one in which it was written.
- R11: A write to address 0 suspends compare and PWM matching. A following write to address 1 resumes it, so the 16-bit value updates as one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current value of the shared counter |
| cnt_ovf | input | 1 | One-cycle strobe: counter wraps at the next clock |
| cap_pin | input | 1 | Asynchronous capture input |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on capture hold) |
| reg_addr | input | ADDR_W | Register address |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data, combinational from address |
| pin_out | output | 1 | Channel output pin |
| evt_flag | output | 1 | One-cycle capture or match event |

## Verification
Capture is driven with pin pulses at arbitrary counter phases, both with no hold and with the upper-byte read hold in place. This separates a blocked capture from one that is merely late. Compare mode is run with three match points. A point inside the period counts plain toggles. Adding toggle-on-wrap should double that count. A match point on the wrap cycle itself separates a single toggle from a double toggle that cancels out. PWM is checked at fixed counter phases before and after full-duty is set and cleared, so that an override taking effect immediately stands apart from one that waits for the boundary. A held upper-byte write is also checked by counting toggles across several periods.

// File: rtl/tim_chan_pkg.sv
package tim_chan_pkg;

   typedef enum logic [1:0] {
      CH_CAPTURE = 2'b00,
      CH_COMPARE = 2'b01,
      CH_PWM     = 2'b10,
      CH_PWM_ALT = 2'b11
   } ch_mode_e;

   // control byte layout, low nibble: mode[3:2], full-duty[1], toggle-on-wrap[0]
   typedef struct packed {
      ch_mode_e mode;
      logic     full_duty;
      logic     tog_wrap;
   } ch_ctrl_t;

   localparam int CTRL_BITS = $bits(ch_ctrl_t);

   function automatic logic mode_is_pwm(input ch_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/tim_chan_sync.sv
module tim_chan_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic last_s;
   logic prev_q;

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("tim_chan_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= din;
         end
         assign last_s = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], din};
         end
         assign last_s = sh_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= last_s;
   end

   assign rise = last_s & ~prev_q;

   // R3: a detected rise is a single-cycle pulse
   assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/tim_chan_regs.sv
module tim_chan_regs
   import tim_chan_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic              cap_rise,
   input  logic [CNT_W-1:0]  cnt_val,
   output logic [CNT_W-1:0]  value,
   output ch_ctrl_t          ctrl,
   output logic              cap_fire,
   output logic              cmp_hold
);
   localparam int NBYTES    = CNT_W / BUS_W;
   localparam int HI_ADDR   = 0;
   localparam int LO_ADDR   = NBYTES - 1;
   localparam int CTRL_ADDR = NBYTES;

   logic [BUS_W-1:0] lane_q [NBYTES];
   ch_ctrl_t         ctrl_q;
   logic             lock_q;
   logic             hold_q;
   logic             rd_hi, rd_lo, wr_hi, wr_lo, wr_ctrl;

   assign rd_hi   = reg_rd && (reg_addr == ADDR_W'(HI_ADDR));
   assign rd_lo   = reg_rd && (reg_addr == ADDR_W'(LO_ADDR));
   assign wr_hi   = reg_wr && (reg_addr == ADDR_W'(HI_ADDR));
   assign wr_lo   = reg_wr && (reg_addr == ADDR_W'(LO_ADDR));
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));

   assign cap_fire = cap_rise && (ctrl_q.mode == CH_CAPTURE) && !lock_q;

   // byte lanes: lane NBYTES-1 is most significant and sits at address 0
   generate
      for (genvar i = 0; i < NBYTES; i++) begin : g_lane
         localparam int LANE_ADDR = NBYTES - 1 - i;
         logic lane_wr;
         assign lane_wr = reg_wr && (reg_addr == ADDR_W'(LANE_ADDR));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        lane_q[i] <= '0;
            else if (lane_wr)  lane_q[i] <= wdata;
            else if (cap_fire) lane_q[i] <= cnt_val[i*BUS_W +: BUS_W];
         end
         assign value[i*BUS_W +: BUS_W] = lane_q[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ch_ctrl_t'(wdata[CTRL_BITS-1:0]);
   end

   // capture hold: upper-byte read while capturing, released by lower-byte read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      lock_q <= 1'b0;
      else if (rd_hi && (ctrl_q.mode == CH_CAPTURE))   lock_q <= 1'b1;
      else if (rd_lo)                                  lock_q <= 1'b0;
   end

   // compare hold: upper-byte write, released by lower-byte write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_q <= 1'b0;
      else if (wr_hi) hold_q <= 1'b1;
      else if (wr_lo) hold_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
         rdata[CTRL_BITS-1:0] = ctrl_q;
      end else begin
         for (int i = 0; i < NBYTES; i++) begin
            if (reg_addr == ADDR_W'(NBYTES - 1 - i)) rdata = lane_q[i];
         end
      end
   end

   assign ctrl     = ctrl_q;
   assign cmp_hold = hold_q;

   // R4: while the capture hold is in place, only a register write alters the value
   assert_cap_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !reg_wr) |=> $stable(value));

   // R4: the hold is released by the lower-byte read
   assert_lock_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !rd_hi) |=> !lock_q);

   // R11: an upper-byte write always leaves matching suspended
   assert_hold_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> cmp_hold);

endmodule

// File: rtl/tim_chan_out.sv
module tim_chan_out
   import tim_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ch_ctrl_t         ctrl,
   input  logic             cmp_hold,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_ovf,
   input  logic [CNT_W-1:0] value,
   input  logic             cap_fire,
   output logic             pin_out,
   output logic             evt_flag
);
   logic pin_q, evt_q, duty_q;
   logic match, is_cmp, is_pwm, duty_force;

   assign is_cmp     = (ctrl.mode == CH_COMPARE);
   assign is_pwm     = mode_is_pwm(ctrl.mode);
   assign match      = (ctrl.mode != CH_CAPTURE) && !cmp_hold && (cnt_val == value);
   assign duty_force = duty_q && !ctrl.tog_wrap;

   // full-duty request is sampled only at the period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       duty_q <= 1'b0;
      else if (cnt_ovf) duty_q <= ctrl.full_duty;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else if (is_cmp) begin
         if (cnt_ovf && ctrl.tog_wrap) pin_q <= ~pin_q;
         else if (match)               pin_q <= ~pin_q;
      end else if (is_pwm) begin
         if (cnt_ovf)                     pin_q <= 1'b1;
         else if (match && !duty_force)   pin_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= cap_fire | match;
   end

   assign pin_out  = pin_q;
   assign evt_flag = evt_q;

   // R6: wrap toggles the pin in compare mode when enabled
   assert_wrap_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmp && ctrl.tog_wrap && cnt_ovf) |=> (pin_q != $past(pin_q)));

   // R7: coincident wrap and match toggle exactly once
   assert_wrap_beats_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmp && ctrl.tog_wrap && cnt_ovf && match) |=> (pin_q != $past(pin_q)));

   // R8: capture mode never moves the pin
   assert_capture_pin_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.mode == CH_CAPTURE) |=> $stable(pin_q));

   // R9: PWM period starts high
   assert_pwm_wrap_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pwm && cnt_ovf) |=> pin_q);

   // R10: with the sampled override active, a high PWM pin stays high
   assert_full_duty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pwm && duty_force && pin_q) |=> pin_q);

   // R11: suspended matching leaves the compare pin alone between wraps
   assert_cmp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmp && cmp_hold && !cnt_ovf) |=> $stable(pin_q));

endmodule

// File: rtl/tim_channel.sv
module tim_channel
   import tim_chan_pkg::*;
#(
   parameter int  CNT_W       = 16,
   parameter int  BUS_W       = 8,
   parameter int  SYNC_STAGES = 2,
   localparam int NBYTES      = CNT_W / BUS_W,
   localparam int ADDR_W      = $clog2(NBYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              cnt_ovf,
   input  logic              cap_pin,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   output logic              pin_out,
   output logic              evt_flag
);
   generate
      if (CNT_W % BUS_W != 0) begin : g_bad_split
         $error("tim_channel: CNT_W must be a multiple of BUS_W");
      end
      if (NBYTES < 2) begin : g_bad_lanes
         $error("tim_channel: value must span at least two bus bytes");
      end
      if (BUS_W < CTRL_BITS) begin : g_bad_bus
         $error("tim_channel: bus too narrow for control byte");
      end
   endgenerate

   logic             cap_rise;
   logic             cap_fire;
   logic             cmp_hold;
   logic [CNT_W-1:0] value;
   ch_ctrl_t         ctrl;

   tim_chan_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cap_pin),
      .rise  (cap_rise)
   );

   tim_chan_regs #(
      .CNT_W  (CNT_W),
      .BUS_W  (BUS_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_addr (reg_addr),
      .wdata    (wdata),
      .rdata    (rdata),
      .cap_rise (cap_rise),
      .cnt_val  (cnt_val),
      .value    (value),
      .ctrl     (ctrl),
      .cap_fire (cap_fire),
      .cmp_hold (cmp_hold)
   );

   tim_chan_out #(
      .CNT_W (CNT_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl     (ctrl),
      .cmp_hold (cmp_hold),
      .cnt_val  (cnt_val),
      .cnt_ovf  (cnt_ovf),
      .value    (value),
      .cap_fire (cap_fire),
      .pin_out  (pin_out),
      .evt_flag (evt_flag)
   );

   // R3: every event pulse is preceded by a capture or a mode that can match
   assert_evt_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flag && $past(ctrl.mode) == CH_CAPTURE) |-> $past(cap_rise));

endmodule

// File: tb/tim_channel_tb_top.sv
module tim_channel_tb_top;
   localparam int CW  = 16;
   localparam int BW  = 8;
   localparam int NS  = 2;
   localparam int TOP = 19;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cnt = '0;
   logic          ovf;
   logic          cap_pin = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [BW-1:0] wdata = '0;
   logic [BW-1:0] rdata;
   logic          pin_out, evt_flag;

   int  errs = 0;
   int  checks = 0;
   bit  run_chk = 1'b0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   assign ovf = (cnt == CW'(TOP));
   always @(posedge clk) begin
      #1;
      cnt = (cnt == CW'(TOP)) ? '0 : cnt + 1'b1;
   end

   tim_channel #(.CNT_W(CW), .BUS_W(BW), .SYNC_STAGES(NS)) dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt), .cnt_ovf(ovf), .cap_pin(cap_pin),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .wdata(wdata),
      .rdata(rdata), .pin_out(pin_out), .evt_flag(evt_flag)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [CW-1:0] m_val;
   logic [3:0]    m_ctl;
   logic [NS-1:0] m_sh;
   bit m_lock, m_hold, m_pin, m_evt, m_max, m_prev;

   always @(posedge clk) begin : model
      int  md;
      bit  fire, mt, tg;
      md = int'(m_ctl[3:2]);
      if (!rst_n) begin
         m_val = '0; m_ctl = '0; m_sh = '0;
         m_lock = 0; m_hold = 0; m_pin = 0; m_evt = 0; m_max = 0; m_prev = 0;
      end else begin
         tg   = m_ctl[0];
         fire = (md == 0) && m_sh[NS-1] && !m_prev && !m_lock;
         mt   = (md != 0) && !m_hold && (cnt == m_val);
         if (md == 1) begin
            if (ovf && tg)  m_pin = !m_pin;
            else if (mt)    m_pin = !m_pin;
         end else if (md >= 2) begin
            if (ovf)                        m_pin = 1;
            else if (mt && !(m_max && !tg)) m_pin = 0;
         end
         if (ovf) m_max = m_ctl[1];
         m_evt = fire || mt;
         if (fire) m_val = cnt;
         if (reg_wr) begin
            case (reg_addr)
               2'd0: begin m_val[15:8] = wdata; m_hold = 1; end
               2'd1: begin m_val[7:0]  = wdata; m_hold = 0; end
               2'd2: m_ctl = wdata[3:0];
               default: ;
            endcase
         end
         if (reg_rd && reg_addr == 2'd0 && md == 0) m_lock = 1;
         else if (reg_rd && reg_addr == 2'd1)       m_lock = 0;
         m_prev = m_sh[NS-1];
         m_sh   = {m_sh[NS-2:0], cap_pin};
      end
   end

   // per-clock comparison against the reference
   always @(negedge clk) begin : compare
      int md, exp_rd;
      md = int'(m_ctl[3:2]);
      if (rst_n && run_chk) begin
         case (reg_addr)
            2'd0: exp_rd = int'(m_val[15:8]);
            2'd1: exp_rd = int'(m_val[7:0]);
            2'd2: exp_rd = int'(m_ctl);
            default: exp_rd = 0;
         endcase
         chk("R2 rdata", int'(rdata), exp_rd);
         if (md == 0)      chk("R8 pin", int'(pin_out), int'(m_pin));
         else if (md == 1) chk("R5 pin", int'(pin_out), int'(m_pin));
         else              chk("R9 pin", int'(pin_out), int'(m_pin));
         if (md == 0) chk("R3 evt", int'(evt_flag), int'(m_evt));
         else         chk("R5 evt", int'(evt_flag), int'(m_evt));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1; reg_addr = a; wdata = d;
      tick(1);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      reg_rd = 1; reg_addr = a;
      #5 v = rdata;
      tick(1);
      reg_rd = 0;
   endtask

   task automatic pulse_cap();
      cap_pin = 1; tick(4);
      cap_pin = 0; tick(4);
   endtask

   task automatic wait_cnt(input int v);
      while (cnt != CW'(v)) tick(1);
   endtask

   task automatic toggles(input int n, output int t);
      logic last;
      last = pin_out;
      t = 0;
      repeat (n) begin
         tick(1);
         if (pin_out != last) t++;
         last = pin_out;
      end
   endtask

   // ---------------- directed sequence ----------------
   initial begin : stim
      logic [7:0]    h, l;
      logic [CW-1:0] saved;
      int            t;
      tick(3);
      chk("R1 pin", int'(pin_out), 0);
      chk("R1 evt", int'(evt_flag), 0);
      for (int a = 0; a < 4; a++) begin
         reg_addr = 2'(a);
         #1 chk("R1 rdata", int'(rdata), 0);
      end
      reg_addr = '0;
      rst_n = 1;
      tick(1);
      run_chk = 1;

      // capture
      pulse_cap();
      rd(2'd0, h); rd(2'd1, l);
      chk("R3 captured", int'({h, l}), int'(m_val));

      // capture hold
      rd(2'd0, h);
      saved = {h, m_val[7:0]};
      tick(3);
      pulse_cap(); tick(5); pulse_cap();
      rd(2'd1, l);
      chk("R4 held low byte", int'(l), int'(saved[7:0]));
      rd(2'd0, h);
      chk("R4 held high byte", int'(h), int'(saved[15:8]));
      rd(2'd1, l);
      tick(7);
      pulse_cap();
      rd(2'd0, h); rd(2'd1, l);
      chk("R4 capture resumed", int'({h, l}), int'(m_val));

      // toggle bit in capture mode
      wr(2'd2, 8'h01);
      toggles(60, t);
      chk("R8 toggles", t, 0);

      // compare
      wr(2'd0, 8'h00); wr(2'd1, 8'd5); wr(2'd2, 8'h04);
      toggles(60, t);
      chk("R5 toggles", t, 3);

      wr(2'd1, 8'd10); wr(2'd2, 8'h05);
      rd(2'd2, h);
      chk("R2 ctrl readback", int'(h), 5);
      toggles(60, t);
      chk("R6 toggles", t, 6);

      wr(2'd1, 8'd19);
      toggles(60, t);
      chk("R7 toggles", t, 3);

      // atomic compare update
      wr(2'd2, 8'h04);
      wr(2'd0, 8'h00);
      toggles(60, t);
      chk("R11 held toggles", t, 0);
      wr(2'd1, 8'd19);
      toggles(60, t);
      chk("R11 resumed toggles", t, 3);

      // PWM
      wr(2'd0, 8'h00); wr(2'd1, 8'd8); wr(2'd2, 8'h08);
      wait_cnt(0); wait_cnt(3);
      chk("R9 high phase", int'(pin_out), 1);
      wait_cnt(12);
      chk("R9 low phase", int'(pin_out), 0);

      // full duty latency
      wr(2'd2, 8'h0A);
      wait_cnt(15);
      chk("R10 not yet forced", int'(pin_out), 0);
      wait_cnt(12);
      chk("R10 forced", int'(pin_out), 1);
      wait_cnt(5);
      wr(2'd2, 8'h08);
      wait_cnt(12);
      chk("R10 still forced", int'(pin_out), 1);
      tick(1);
      wait_cnt(12);
      chk("R10 released", int'(pin_out), 0);

      tick(5);
      run_chk = 0;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule